// File: doc/BRIEF.md
# Control and Status Register Bank with Slow-Read Window

This block is a register slave on a plain request/response word bus. A request carries a write flag, a word address, write data and per-byte write strobes, and it is accepted when the request valid and ready signals are both high. Every accepted request, read or write, receives exactly one response pulse on `rsp_valid_o`. A read response carries the read data on that pulse.

Behind the decoder are registers that each follow one access rule. There is a plain read/write control word, a word whose written ones set bits, and a status word whose written ones clear bits while hardware sets them. There is also an event accumulator that clears itself when read, a wide register spread over consecutive word addresses, and a narrow field placed at a fixed bit offset. A slow status word answers only after a configurable number of cycles, and an address window fronts a synchronous-read memory that answers two cycles after the request. Until a multi-cycle read has answered, `req_ready_o` stays low.

Top module: `csr_bank`

## Requirements
- R1: After reset `req_ready_o` is 1, `rsp_valid_o` is 0, and `ctrl_o`, `setreg_o`, `stat_o`, `wide_o` and `field_o` are all zero.
- R2: Word address 0x00 is a plain read/write register (`ctrl_o`). Strobe bit b enables data bits [8b+7:8b], and bytes with a strobe of 0 keep their value.
- R3: At address 0x01 (`setreg_o`, readable), each written 1 bit in a strobed byte sets the register bit. Written 0 bits leave the register unchanged.
- R4: At address 0x02 (`stat_o`, readable), each written 1 bit in a strobed byte clears the register bit. Each 1 bit on `stat_set_i` sets the bit in every cycle, and when both happen together the set wins.
- R5: Address 0x03 ORs `evt_i` into itself on every clock edge. A read returns the value held before its accept edge, and at that edge the register is loaded with that cycle's `evt_i` only. Writes to it are ignored.
- R6: The wide register of WIDE_WORDS words (default 2) starts at address 0x04, one word per address in little-word order: address 0x04 holds `wide_o[31:0]` and address 0x05 holds `wide_o[63:32]`. It is readable and writable with strobes.
- R7: Address 0x06 holds an 8-bit field at bus bits [15:8] (`field_o`). The field is written from those bits under their strobe, and all other read bits are 0.
- R8: Address 0x07 is read-only. Its read response comes SLOW_LAT cycles after the accept edge (default 3) and carries `slow_data_i` as it is in the response cycle. Writes to it are ignored.
- R9: Addresses 0x40 to 0x4F map a 16-word memory. A write stores the whole data word regardless of strobes. A read responds 2 cycles after the accept edge with the stored word.
- R10: All writes and all other reads respond 1 cycle after the accept edge. While a read with latency above 1 is pending, `req_ready_o` is 0.
- R11: Any other address reads as zero, and writes to it change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| req_valid_i | input | 1 | Request present |
| req_ready_o | output | 1 | Request can be accepted this cycle |
| req_write_i | input | 1 | 1 = write, 0 = read |
| req_addr_i | input | 8 | Word address |
| req_wdata_i | input | 32 | Write data |
| req_wstrb_i | input | 4 | Per-byte write enables |
| rsp_valid_o | output | 1 | One-cycle response pulse |
| rsp_rdata_o | output | 32 | Read data, valid with the response of a read |
| evt_i | input | 32 | Event bits accumulated by the sticky register |
| stat_set_i | input | 32 | Hardware set bits for the status register |
| slow_data_i | input | 32 | Value returned by the slow status read |
| ctrl_o | output | 32 | Control register contents |
| setreg_o | output | 32 | Write-one-to-set register contents |
| stat_o | output | 32 | Status register contents |
| wide_o | output | 64 | Wide register contents |
| field_o | output | 8 | Offset field contents |

## Verification
The assertions assume that `stat_set_i` and `evt_i` are sampled only at clock edges and that a requester keeps its request stable until it is accepted. The bench drives all inputs on the falling edge and holds each request until the ready signal is seen high. It keeps the event and set inputs at zero except in directed pulses of one cycle, so the reference model knows which edge each of those bits arrives at. The latency checks assume the address never points into the memory window beyond its depth, and the random address draw keeps to mapped windows and to clearly unmapped ranges.

// File: rtl/csr_bank_pkg.sv
package csr_bank_pkg;
  typedef enum logic [3:0] {
    K_NONE, K_CTRL, K_SET, K_CLR, K_STICKY, K_WIDE, K_FIELD, K_SLOW, K_MEM
  } acc_kind_e;

  localparam int unsigned CTRL_ADDR   = 0;
  localparam int unsigned SET_ADDR    = 1;
  localparam int unsigned CLR_ADDR    = 2;
  localparam int unsigned STICKY_ADDR = 3;
  localparam int unsigned WIDE_BASE   = 4;
  localparam int unsigned MEM_BASE    = 64;
  localparam int unsigned MEM_RD_LAT  = 2;
endpackage

// File: rtl/csr_decode.sv
module csr_decode
  import csr_bank_pkg::*;
#(
  parameter int unsigned AW         = 8,
  parameter int unsigned WIDE_WORDS = 2,
  parameter int unsigned MEM_DEPTH  = 16,
  localparam int unsigned WIW = (WIDE_WORDS > 1) ? $clog2(WIDE_WORDS) : 1,
  localparam int unsigned MIW = (MEM_DEPTH > 1) ? $clog2(MEM_DEPTH) : 1
) (
  input  logic [AW-1:0]  addr_i,
  output acc_kind_e      kind_o,
  output logic [WIW-1:0] widx_o,
  output logic [MIW-1:0] midx_o
);
  localparam int unsigned FIELD_ADDR = WIDE_BASE + WIDE_WORDS;
  localparam int unsigned SLOW_ADDR  = FIELD_ADDR + 1;

  int unsigned a;

  always_comb begin
    a      = 32'(addr_i);
    kind_o = K_NONE;
    widx_o = WIW'(a - WIDE_BASE);
    midx_o = MIW'(a - MEM_BASE);
    if (a == CTRL_ADDR)                                   kind_o = K_CTRL;
    else if (a == SET_ADDR)                               kind_o = K_SET;
    else if (a == CLR_ADDR)                               kind_o = K_CLR;
    else if (a == STICKY_ADDR)                            kind_o = K_STICKY;
    else if (a >= WIDE_BASE && a < FIELD_ADDR)            kind_o = K_WIDE;
    else if (a == FIELD_ADDR)                             kind_o = K_FIELD;
    else if (a == SLOW_ADDR)                              kind_o = K_SLOW;
    else if (a >= MEM_BASE && a < MEM_BASE + MEM_DEPTH)   kind_o = K_MEM;
  end
endmodule

// File: rtl/csr_lat_seq.sv
module csr_lat_seq #(
  parameter int unsigned MAX_LAT = 3,
  localparam int unsigned LW = $clog2(MAX_LAT + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          accept_i,
  input  logic [LW-1:0] lat_i,
  output logic          ready_o,
  output logic          rsp_valid_o
);
  logic [LW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)            cnt_q <= '0;
    else if (accept_i)      cnt_q <= lat_i;
    else if (cnt_q != '0)   cnt_q <= cnt_q - 1'b1;
  end

  // final countdown cycle is the response; a new request may overlap it
  assign ready_o     = (cnt_q <= LW'(1));
  assign rsp_valid_o = (cnt_q == LW'(1));

  p_lat_nonzero_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    accept_i |-> (lat_i != '0));
endmodule

// File: rtl/csr_mem.sv
module csr_mem #(
  parameter int unsigned DW    = 32,
  parameter int unsigned DEPTH = 16,
  localparam int unsigned MIW = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           we_i,
  input  logic           re_i,
  input  logic [MIW-1:0] idx_i,
  input  logic [DW-1:0]  wdata_i,
  output logic [DW-1:0]  rdata_o
);
  logic [DW-1:0]  mem_q [DEPTH];
  logic [MIW-1:0] raddr_q;
  logic [DW-1:0]  rd_q;

  always_ff @(posedge clk_i) begin
    if (we_i) mem_q[idx_i] <= wdata_i;
  end

  // stage 1: address capture, stage 2: array read
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      raddr_q <= '0;
      rd_q    <= '0;
    end else begin
      if (re_i) raddr_q <= idx_i;
      rd_q <= mem_q[raddr_q];
    end
  end

  assign rdata_o = rd_q;
endmodule

// File: rtl/csr_regs.sv
module csr_regs
  import csr_bank_pkg::*;
#(
  parameter int unsigned DW         = 32,
  parameter int unsigned WIDE_WORDS = 2,
  parameter int unsigned FW         = 8,
  parameter int unsigned FOFS       = 8,
  localparam int unsigned WIW = (WIDE_WORDS > 1) ? $clog2(WIDE_WORDS) : 1
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     acc_i,
  input  logic                     wr_i,
  input  acc_kind_e                kind_i,
  input  logic [WIW-1:0]           widx_i,
  input  logic [DW-1:0]            wdata_i,
  input  logic [DW-1:0]            mask_i,
  input  logic [DW-1:0]            evt_i,
  input  logic [DW-1:0]            stat_set_i,
  output logic [DW-1:0]            rdata_o,
  output logic [DW-1:0]            ctrl_o,
  output logic [DW-1:0]            setreg_o,
  output logic [DW-1:0]            stat_o,
  output logic [DW*WIDE_WORDS-1:0] wide_o,
  output logic [FW-1:0]            field_o
);
  logic [DW-1:0] ctrl_q, setr_q, stat_q, sticky_q;
  logic [DW-1:0] wide_q [WIDE_WORDS];
  logic [FW-1:0] field_q;
  logic [DW-1:0] wbits, clr_bits;
  logic [FW-1:0] fmask;
  logic          wen, sticky_rd;

  assign wen       = acc_i && wr_i;
  assign sticky_rd = acc_i && !wr_i && (kind_i == K_STICKY);
  assign wbits     = wdata_i & mask_i;
  assign clr_bits  = (wen && kind_i == K_CLR) ? wbits : '0;
  assign fmask     = mask_i[FOFS +: FW];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_q   <= '0;
      setr_q   <= '0;
      stat_q   <= '0;
      sticky_q <= '0;
      field_q  <= '0;
    end else begin
      if (wen && kind_i == K_CTRL) ctrl_q <= (ctrl_q & ~mask_i) | wbits;
      if (wen && kind_i == K_SET)  setr_q <= setr_q | wbits;
      stat_q   <= (stat_q & ~clr_bits) | stat_set_i;
      sticky_q <= sticky_rd ? evt_i : (sticky_q | evt_i);
      if (wen && kind_i == K_FIELD)
        field_q <= (field_q & ~fmask) | (wdata_i[FOFS +: FW] & fmask);
    end
  end

  for (genvar w = 0; w < WIDE_WORDS; w++) begin : g_wide
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) wide_q[w] <= '0;
      else if (wen && kind_i == K_WIDE && widx_i == WIW'(w))
        wide_q[w] <= (wide_q[w] & ~mask_i) | wbits;
    end
    assign wide_o[w*DW +: DW] = wide_q[w];
  end

  always_comb begin
    unique case (kind_i)
      K_CTRL:   rdata_o = ctrl_q;
      K_SET:    rdata_o = setr_q;
      K_CLR:    rdata_o = stat_q;
      K_STICKY: rdata_o = sticky_q;
      K_WIDE:   rdata_o = wide_q[widx_i];
      K_FIELD:  rdata_o = DW'(field_q) << FOFS;
      default:  rdata_o = '0;
    endcase
  end

  assign ctrl_o   = ctrl_q;
  assign setreg_o = setr_q;
  assign stat_o   = stat_q;
  assign field_o  = field_q;

  p_w1s_keep_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wen && kind_i == K_SET) |=> ((setr_q & $past(setr_q)) == $past(setr_q)));

  p_w1c_noset_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wen && kind_i == K_CLR) |=> ((stat_q & ~($past(stat_q) | $past(stat_set_i))) == '0));

  p_sticky_hold_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !sticky_rd |=> ((sticky_q & $past(sticky_q)) == $past(sticky_q)));
endmodule

// File: rtl/csr_bank.sv
module csr_bank
  import csr_bank_pkg::*;
#(
  parameter int unsigned AW         = 8,
  parameter int unsigned DW         = 32,
  parameter int unsigned WIDE_WORDS = 2,
  parameter int unsigned FW         = 8,
  parameter int unsigned FOFS       = 8,
  parameter int unsigned SLOW_LAT   = 3,
  parameter int unsigned MEM_DEPTH  = 16
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     req_valid_i,
  output logic                     req_ready_o,
  input  logic                     req_write_i,
  input  logic [AW-1:0]            req_addr_i,
  input  logic [DW-1:0]            req_wdata_i,
  input  logic [DW/8-1:0]          req_wstrb_i,
  output logic                     rsp_valid_o,
  output logic [DW-1:0]            rsp_rdata_o,
  input  logic [DW-1:0]            evt_i,
  input  logic [DW-1:0]            stat_set_i,
  input  logic [DW-1:0]            slow_data_i,
  output logic [DW-1:0]            ctrl_o,
  output logic [DW-1:0]            setreg_o,
  output logic [DW-1:0]            stat_o,
  output logic [DW*WIDE_WORDS-1:0] wide_o,
  output logic [FW-1:0]            field_o
);
  localparam int unsigned SW      = DW / 8;
  localparam int unsigned WIW     = (WIDE_WORDS > 1) ? $clog2(WIDE_WORDS) : 1;
  localparam int unsigned MIW     = (MEM_DEPTH > 1) ? $clog2(MEM_DEPTH) : 1;
  localparam int unsigned MAX_LAT = (SLOW_LAT > MEM_RD_LAT) ? SLOW_LAT : MEM_RD_LAT;
  localparam int unsigned LW      = $clog2(MAX_LAT + 1);

  acc_kind_e      kind, kind_q;
  logic [WIW-1:0] widx;
  logic [MIW-1:0] midx;
  logic [DW-1:0]  mask, reg_rd, mem_rd, rdata_q;
  logic [LW-1:0]  lat_sel;
  logic           accept, wr_q;

  for (genvar b = 0; b < SW; b++) begin : g_mask
    assign mask[b*8 +: 8] = {8{req_wstrb_i[b]}};
  end

  csr_decode #(.AW(AW), .WIDE_WORDS(WIDE_WORDS), .MEM_DEPTH(MEM_DEPTH)) u_dec (
    .addr_i (req_addr_i),
    .kind_o (kind),
    .widx_o (widx),
    .midx_o (midx)
  );

  assign accept = req_valid_i && req_ready_o;

  always_comb begin
    lat_sel = LW'(1);
    if (!req_write_i && kind == K_MEM)  lat_sel = LW'(MEM_RD_LAT);
    if (!req_write_i && kind == K_SLOW) lat_sel = LW'(SLOW_LAT);
  end

  csr_lat_seq #(.MAX_LAT(MAX_LAT)) u_seq (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .accept_i    (accept),
    .lat_i       (lat_sel),
    .ready_o     (req_ready_o),
    .rsp_valid_o (rsp_valid_o)
  );

  csr_regs #(.DW(DW), .WIDE_WORDS(WIDE_WORDS), .FW(FW), .FOFS(FOFS)) u_regs (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .acc_i      (accept),
    .wr_i       (req_write_i),
    .kind_i     (kind),
    .widx_i     (widx),
    .wdata_i    (req_wdata_i),
    .mask_i     (mask),
    .evt_i      (evt_i),
    .stat_set_i (stat_set_i),
    .rdata_o    (reg_rd),
    .ctrl_o     (ctrl_o),
    .setreg_o   (setreg_o),
    .stat_o     (stat_o),
    .wide_o     (wide_o),
    .field_o    (field_o)
  );

  csr_mem #(.DW(DW), .DEPTH(MEM_DEPTH)) u_mem (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (accept && req_write_i && kind == K_MEM),
    .re_i    (accept && !req_write_i && kind == K_MEM),
    .idx_i   (midx),
    .wdata_i (req_wdata_i),
    .rdata_o (mem_rd)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      kind_q  <= K_NONE;
      wr_q    <= 1'b0;
      rdata_q <= '0;
    end else if (accept) begin
      kind_q  <= kind;
      wr_q    <= req_write_i;
      rdata_q <= req_write_i ? '0 : reg_rd;
    end
  end

  always_comb begin
    rsp_rdata_o = rdata_q;
    if (!wr_q && kind_q == K_MEM)  rsp_rdata_o = mem_rd;
    if (!wr_q && kind_q == K_SLOW) rsp_rdata_o = slow_data_i;
  end

  p_mem_wait_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (accept && !req_write_i && kind == K_MEM) |=> (!rsp_valid_o && !req_ready_o));

  p_unmapped_inert_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (accept && kind == K_NONE) |=>
      ($stable(ctrl_o) && $stable(setreg_o) && $stable(wide_o) && $stable(field_o)));
endmodule

// File: tb/sim_csr_bank.sv
module sim_csr_bank;
  localparam int CLK_PERIOD = 10;
  localparam int SLOW_LAT   = 3;
  localparam int MEM_DEPTH  = 16;

  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        req_valid_i = 1'b0, req_write_i = 1'b0;
  logic [7:0]  req_addr_i = '0;
  logic [31:0] req_wdata_i = '0;
  logic [3:0]  req_wstrb_i = '0;
  logic        req_ready_o, rsp_valid_o;
  logic [31:0] rsp_rdata_o;
  logic [31:0] evt_i = '0, stat_set_i = '0, slow_data_i = '0;
  logic [31:0] ctrl_o, setreg_o, stat_o;
  logic [63:0] wide_o;
  logic [7:0]  field_o;

  int vectors = 0, miscompares = 0;

  // reference state
  logic [31:0] m_ctrl = '0, m_set = '0, m_stat = '0, m_sticky = '0;
  logic [31:0] m_wide [2];
  logic [7:0]  m_field = '0;
  logic [31:0] m_mem [MEM_DEPTH];

  always #(CLK_PERIOD/2) clk = ~clk;

  csr_bank #(.SLOW_LAT(SLOW_LAT), .MEM_DEPTH(MEM_DEPTH)) u0 (
    .clk_i(clk), .rst_ni(rst_ni),
    .req_valid_i(req_valid_i), .req_ready_o(req_ready_o), .req_write_i(req_write_i),
    .req_addr_i(req_addr_i), .req_wdata_i(req_wdata_i), .req_wstrb_i(req_wstrb_i),
    .rsp_valid_o(rsp_valid_o), .rsp_rdata_o(rsp_rdata_o),
    .evt_i(evt_i), .stat_set_i(stat_set_i), .slow_data_i(slow_data_i),
    .ctrl_o(ctrl_o), .setreg_o(setreg_o), .stat_o(stat_o), .wide_o(wide_o), .field_o(field_o)
  );

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    vectors++;
    if (act !== exp) begin
      miscompares++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] smask(input logic [3:0] s);
    logic [31:0] m;
    for (int b = 0; b < 4; b++) m[b*8 +: 8] = {8{s[b]}};
    return m;
  endfunction

  function automatic logic [31:0] model_rd(input logic [7:0] a);
    if (a == 8'h00) return m_ctrl;
    if (a == 8'h01) return m_set;
    if (a == 8'h02) return m_stat;
    if (a == 8'h03) return m_sticky;
    if (a == 8'h04) return m_wide[0];
    if (a == 8'h05) return m_wide[1];
    if (a == 8'h06) return {16'h0, m_field, 8'h0};
    if (a == 8'h07) return slow_data_i;
    if (a >= 8'h40 && a < 8'h40 + MEM_DEPTH) return m_mem[a - 8'h40];
    return '0;
  endfunction

  function automatic int model_lat(input logic w, input logic [7:0] a);
    if (w) return 1;
    if (a == 8'h07) return SLOW_LAT;
    if (a >= 8'h40 && a < 8'h40 + MEM_DEPTH) return 2;
    return 1;
  endfunction

  task automatic model_access(input logic w, input logic [7:0] a, input logic [31:0] d,
                              input logic [3:0] s);
    logic [31:0] m, wb;
    m = smask(s);
    wb = d & m;
    if (!w) begin
      if (a == 8'h03) m_sticky = '0;
      return;
    end
    if (a == 8'h00) m_ctrl = (m_ctrl & ~m) | wb;
    if (a == 8'h01) m_set = m_set | wb;
    if (a == 8'h02) m_stat = m_stat & ~wb;
    if (a == 8'h04) m_wide[0] = (m_wide[0] & ~m) | wb;
    if (a == 8'h05) m_wide[1] = (m_wide[1] & ~m) | wb;
    if (a == 8'h06) m_field = (m_field & ~m[15:8]) | wb[15:8];
    if (a >= 8'h40 && a < 8'h40 + MEM_DEPTH) m_mem[a - 8'h40] = d;
  endtask

  task automatic bus(input logic w, input logic [7:0] a, input logic [31:0] d,
                     input logic [3:0] s, output logic [31:0] rd, output int lat,
                     output logic rdy1);
    int guard;
    @(negedge clk);
    req_valid_i = 1'b1; req_write_i = w; req_addr_i = a; req_wdata_i = d; req_wstrb_i = s;
    guard = 0;
    while (!req_ready_o && guard < 50) begin @(negedge clk); guard++; end
    @(posedge clk);
    @(negedge clk);
    req_valid_i = 1'b0;
    lat = 1;
    rdy1 = req_ready_o;
    while (!rsp_valid_o && lat < 50) begin @(negedge clk); lat++; end
    rd = rsp_rdata_o;
  endtask

  // full transaction with model comparison
  task automatic xfer(input string req, input logic w, input logic [7:0] a,
                      input logic [31:0] d, input logic [3:0] s);
    logic [31:0] rd, exp;
    int lat, elat;
    logic rdy1;
    exp  = model_rd(a);
    elat = model_lat(w, a);
    bus(w, a, d, s, rd, lat, rdy1);
    chk({req, " latency"}, 64'(lat), 64'(elat));
    if (!w) chk({req, " read data"}, 64'(rd), 64'(exp));
    if (elat > 1) chk({req, " R10 ready low while pending"}, 64'(rdy1), 64'(0));
    model_access(w, a, d, s);
  endtask

  task automatic pulse_evt(input logic [31:0] v);
    @(negedge clk); evt_i = v;
    @(negedge clk); evt_i = '0;
    m_sticky = m_sticky | v;
  endtask

  task automatic pulse_stat(input logic [31:0] v);
    @(negedge clk); stat_set_i = v;
    @(negedge clk); stat_set_i = '0;
    m_stat = m_stat | v;
  endtask

  task automatic check_outputs(input string req);
    chk({req, " ctrl_o"},   64'(ctrl_o),   64'(m_ctrl));
    chk({req, " setreg_o"}, 64'(setreg_o), 64'(m_set));
    chk({req, " stat_o"},   64'(stat_o),   64'(m_stat));
    chk({req, " wide_o"},   wide_o,        {m_wide[1], m_wide[0]});
    chk({req, " field_o"},  64'(field_o),  64'(m_field));
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    miscompares++; vectors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    logic [7:0]  a;
    logic [31:0] d;
    void'($urandom(32'd20250611));
    m_wide[0] = '0; m_wide[1] = '0;
    for (int i = 0; i < MEM_DEPTH; i++) m_mem[i] = '0;

    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1 ready", 64'(req_ready_o), 64'(1));
    chk("R1 rsp_valid", 64'(rsp_valid_o), 64'(0));
    check_outputs("R1");
    rst_ni = 1'b1;

    // R9 fill memory, then read back
    for (int i = 0; i < MEM_DEPTH; i++) xfer("R9 fill", 1'b1, 8'(8'h40 + i), $urandom, 4'h0);
    for (int i = 0; i < MEM_DEPTH; i++) xfer("R9 read", 1'b0, 8'(8'h40 + i), 0, 4'h0);

    // R2 byte strobes
    xfer("R2 strobe write", 1'b1, 8'h00, 32'hFFFF_FFFF, 4'b0101);
    chk("R2 ctrl after strobes", 64'(ctrl_o), 64'h00FF_00FF);
    xfer("R2 read", 1'b0, 8'h00, 0, 4'h0);

    // R3 write-one-to-set
    xfer("R3 set low", 1'b1, 8'h01, 32'h0000_000F, 4'hF);
    xfer("R3 set high", 1'b1, 8'h01, 32'h0000_00F0, 4'hF);
    xfer("R3 zeros", 1'b1, 8'h01, 32'h0, 4'hF);
    chk("R3 setreg", 64'(setreg_o), 64'h0000_00FF);

    // R4 write-one-to-clear with hardware set
    pulse_stat(32'hA5A5_0001);
    xfer("R4 read", 1'b0, 8'h02, 0, 4'h0);
    xfer("R4 clear", 1'b1, 8'h02, 32'h8000_0000, 4'hF);
    chk("R4 cleared", 64'(stat_o), 64'h25A5_0001);
    @(negedge clk); stat_set_i = 32'h1;
    xfer("R4 set wins", 1'b1, 8'h02, 32'h0000_0001, 4'hF);
    chk("R4 set wins", 64'(stat_o), 64'h25A5_0001);
    stat_set_i = '0;
    m_stat = m_stat | 32'h1;

    // R5 sticky accumulate and clear-on-read
    pulse_evt(32'h11);
    pulse_evt(32'h22);
    xfer("R5 write ignored", 1'b1, 8'h03, 32'hFFFF_FFFF, 4'hF);
    xfer("R5 first read", 1'b0, 8'h03, 0, 4'h0);
    xfer("R5 second read", 1'b0, 8'h03, 0, 4'h0);

    // R6 wide register, little-word order
    xfer("R6 lo", 1'b1, 8'h04, 32'h1122_3344, 4'hF);
    xfer("R6 hi", 1'b1, 8'h05, 32'h5566_7788, 4'hF);
    chk("R6 wide_o", wide_o, 64'h5566_7788_1122_3344);
    xfer("R6 read hi", 1'b0, 8'h05, 0, 4'h0);

    // R7 offset field
    xfer("R7 write", 1'b1, 8'h06, 32'hFFFF_FFFF, 4'hF);
    chk("R7 field_o", 64'(field_o), 64'hFF);
    xfer("R7 read", 1'b0, 8'h06, 0, 4'h0);
    xfer("R7 strobe off", 1'b1, 8'h06, 32'h0, 4'b1101);
    chk("R7 field kept", 64'(field_o), 64'hFF);

    // R8 slow read
    slow_data_i = 32'hCAFE_F00D;
    xfer("R8 slow read", 1'b0, 8'h07, 0, 4'h0);
    xfer("R8 write ignored", 1'b1, 8'h07, 32'h1234_5678, 4'hF);
    check_outputs("R8");

    // R11 unmapped
    xfer("R11 write", 1'b1, 8'h20, 32'hFFFF_FFFF, 4'hF);
    xfer("R11 read", 1'b0, 8'h20, 0, 4'h0);
    xfer("R11 read above window", 1'b0, 8'h50, 0, 4'h0);
    check_outputs("R11");

    // R10 mixed random traffic
    for (int i = 0; i < 400; i++) begin
      case ($urandom % 4)
        0, 1: a = 8'($urandom % 8);
        2: a = 8'(8'h40 + $urandom % MEM_DEPTH);
        default: a = ($urandom % 2) ? 8'(8 + $urandom % 56) : 8'(8'h50 + $urandom % 176);
      endcase
      d = $urandom;
      slow_data_i = $urandom;
      xfer("R10 random", 1'($urandom % 2), a, d, 4'($urandom));
    end
    check_outputs("R10 final");

    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule